// File: doc/BRIEF.md
# Serial Bridge Frame Engine

This block is a serial master for a single-wire-data (SPI-style) link. It sends an outbound word and collects an inbound word in one transaction. Software sets it up with plain register writes: frame length, per-frame transmit and receive windows, clock polarity and phase, a bit-rate divider, a choice of one or two frames, a gap between frames, and a mask that picks which of the chip-select lines are driven.

A write of the transmit word starts a transaction if the bridge is enabled. A busy flag stays high until the last bit of the last frame. Software polls that flag and then reads the captured word. In the two-frame mode, the first frame usually only transmits and the second only receives. Chip select goes inactive for a programmable number of ticks between the frames. Two sticky flags record completion and a rejected start. A command write clears them.

Each serial bit lasts eight divider ticks, and one tick is (divider + 1) system clocks. The divider value for a target rate is therefore f_sys / (8 · f_bit) − 1.

Top module: `serial_frame_bridge`

## Requirements
- R1: After reset, the status word (address 5) and the receive word (address 7) read 0. The mode word (address 2) reads 0x4000, which is port mask 001. All chip selects are high and sclk is low.
- R2: Writing address 6 while the enable bit (mode bit 0) is 1 and the block is idle starts a transaction. Status bit 0 (busy) reads 1 from the next cycle. If the enable bit is 0, the write is ignored: busy stays 0 and no chip select falls.
- R3: Every bit lasts 8·(div+1) system clocks, where div is mode bits [12:3]. sclk idles at the level in mode bit 1 (cpol). When mode bit 2 (cpha) is 0, data is sampled on the first edge of each bit; when it is 1, on the second edge. Chip select stays low for frames·len·8·(div+1) clocks.
- R4: Data leaves on mosi MSB first. The first out_count bits of each frame carry the next bits of the transmit word, and zeros follow once 32 bits have gone. Outside that window mosi is 0. mosi changes only at bit boundaries.
- R5: Setting mode bit 13 runs two frames. Chip select is high between them for (gap+1)·(div+1) clocks, where gap is address 3 bits [16:0]. Transmit bits continue from where frame one stopped.
- R6: In each frame, bits with index b where in_delay ≤ b < in_delay+in_count are shifted into the receive word from the LSB. The receive word is cleared at start and becomes readable at address 7 when the transaction ends. Frame one's fields are address 0: len [5:0], out [11:6], delay [17:12], in [23:18]. Frame two's fields are address 1: out [5:0], delay [11:6], in [17:12].
- R7: When the last bit ends, busy clears and sticky done (status bit 1) sets.
- R8: A write to address 6 while busy is ignored: the transfer in flight is unchanged. It sets sticky overrun (status bit 2).
- R9: Writing address 4 with bit 1 set clears both sticky flags. A write with bit 1 clear leaves them unchanged.
- R10: Only ports whose bit is set in mode bits [16:14] drive their chip select low. miso is taken only from enabled ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 3 | Serial data in, one per port |
| cs_n | output | 3 | Active-low chip selects, one per port |

## Verification
If the bit counter or the phase counter is wrong, the shape of chip select shows it at once. Its low time and the gap length are measured in clocks, so an error shows up within the first frame. A wrong transmit shifter or a wrong receive window shows up on the serial pins. A slave model records every mosi bit and returns a known sequence on miso, so a single misplaced bit is visible. The captured word is then compared against the value the bench computes as soon as busy drops. Errors in the flags show up on the first status read after a rejected start, a clear, or a completion.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_FRAME, SQ_GAP} sq_state_e;
   localparam logic [2:0] A_FRAME1 = 3'd0;
   localparam logic [2:0] A_FRAME2 = 3'd1;
   localparam logic [2:0] A_MODE   = 3'd2;
   localparam logic [2:0] A_GAP    = 3'd3;
   localparam logic [2:0] A_CMD    = 3'd4;
   localparam logic [2:0] A_STAT   = 3'd5;
   localparam logic [2:0] A_TXD    = 3'd6;
   localparam logic [2:0] A_RXD    = 3'd7;
   localparam int CLR_BIT = 1;
endpackage

// File: rtl/sfb_tick_gen.sv
module sfb_tick_gen #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || tick)  cnt <= '0;
      else                    cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/sfb_cfg_regs.sv
module sfb_cfg_regs import sfb_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6,
   parameter int DIV_W  = 10,
   parameter int GAP_W  = 17,
   parameter int NPORT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              busy,
   input  logic              finish,
   input  logic [DATA_W-1:0] rx_word,
   output logic              start,
   output logic [DATA_W-1:0] tx_word,
   output logic              cpol,
   output logic              cpha,
   output logic [DIV_W-1:0]  div,
   output logic              two_frames,
   output logic [NPORT-1:0]  port_en,
   output logic [CNT_W-1:0]  frame_len,
   output logic [CNT_W-1:0]  out_a,
   output logic [CNT_W-1:0]  dly_a,
   output logic [CNT_W-1:0]  in_a,
   output logic [CNT_W-1:0]  out_b,
   output logic [CNT_W-1:0]  dly_b,
   output logic [CNT_W-1:0]  in_b,
   output logic [GAP_W-1:0]  gap_ticks
);
   localparam int FA_W   = 4 * CNT_W;
   localparam int FB_W   = 3 * CNT_W;
   localparam int DIV_LO = 3;
   localparam int TWO_B  = DIV_LO + DIV_W;
   localparam int PORT_LO = TWO_B + 1;
   localparam int MODE_W = PORT_LO + NPORT;
   localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(1) << PORT_LO;

   if (FA_W > DATA_W || MODE_W > DATA_W || GAP_W > DATA_W) begin : g_bad_map
      $error("sfb_cfg_regs: a register field map does not fit the data width");
   end

   logic [FA_W-1:0]   frame_a_q;
   logic [FB_W-1:0]   frame_b_q;
   logic [MODE_W-1:0] mode_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] rx_q;
   logic              done_stk, ovr_stk;
   logic              wr_tx, clr;

   assign wr_tx = wr_en && (wr_addr == A_TXD);
   assign clr   = wr_en && (wr_addr == A_CMD) && wr_data[CLR_BIT];
   assign start = wr_tx && mode_q[0] && !busy;
   assign tx_word = wr_data;

   assign frame_len  = frame_a_q[0*CNT_W +: CNT_W];
   assign out_a      = frame_a_q[1*CNT_W +: CNT_W];
   assign dly_a      = frame_a_q[2*CNT_W +: CNT_W];
   assign in_a       = frame_a_q[3*CNT_W +: CNT_W];
   assign out_b      = frame_b_q[0*CNT_W +: CNT_W];
   assign dly_b      = frame_b_q[1*CNT_W +: CNT_W];
   assign in_b       = frame_b_q[2*CNT_W +: CNT_W];
   assign cpol       = mode_q[1];
   assign cpha       = mode_q[2];
   assign div        = mode_q[DIV_LO +: DIV_W];
   assign two_frames = mode_q[TWO_B];
   assign port_en    = mode_q[PORT_LO +: NPORT];
   assign gap_ticks  = gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_a_q <= '0;
         frame_b_q <= '0;
         mode_q    <= MODE_RST;
         gap_q     <= '0;
         rx_q      <= '0;
         done_stk  <= 1'b0;
         ovr_stk   <= 1'b0;
      end else begin
         if (wr_en && wr_addr == A_FRAME1) frame_a_q <= wr_data[FA_W-1:0];
         if (wr_en && wr_addr == A_FRAME2) frame_b_q <= wr_data[FB_W-1:0];
         if (wr_en && wr_addr == A_MODE)   mode_q    <= wr_data[MODE_W-1:0];
         if (wr_en && wr_addr == A_GAP)    gap_q     <= wr_data[GAP_W-1:0];
         if (finish) rx_q <= rx_word;
         if (finish)   done_stk <= 1'b1;
         else if (clr) done_stk <= 1'b0;
         if (wr_tx && busy) ovr_stk <= 1'b1;
         else if (clr)      ovr_stk <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_FRAME1: rd_data[FA_W-1:0]   = frame_a_q;
         A_FRAME2: rd_data[FB_W-1:0]   = frame_b_q;
         A_MODE:   rd_data[MODE_W-1:0] = mode_q;
         A_GAP:    rd_data[GAP_W-1:0]  = gap_q;
         A_STAT:   rd_data[2:0]        = {ovr_stk, done_stk, busy};
         A_RXD:    rd_data             = rx_q;
         default:  rd_data = '0;
      endcase
   end

   // R8
   ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx && busy) |=> ovr_stk);
   // R9
   clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !finish) |=> !done_stk);
endmodule

// File: rtl/sfb_frame_seq.sv
module sfb_frame_seq import sfb_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6,
   parameter int GAP_W  = 17,
   parameter int TPB    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic              two_frames,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              miso_bit,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [CNT_W-1:0]  frame_len,
   input  logic [CNT_W-1:0]  out_a,
   input  logic [CNT_W-1:0]  dly_a,
   input  logic [CNT_W-1:0]  in_a,
   input  logic [CNT_W-1:0]  out_b,
   input  logic [CNT_W-1:0]  dly_b,
   input  logic [CNT_W-1:0]  in_b,
   input  logic [GAP_W-1:0]  gap_ticks,
   output logic              busy,
   output logic              finish,
   output logic              cs_active,
   output logic              sclk,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_word
);
   localparam int PH_W = (TPB > 2) ? $clog2(TPB) : 1;
   localparam int HALF = TPB / 2;

   if (TPB < 2 || (TPB % 2) != 0 || DATA_W < 2) begin : g_bad_tpb
      $error("sfb_frame_seq: ticks per bit must be even and at least 2");
   end

   sq_state_e         state;
   logic              second;
   logic [CNT_W-1:0]  bitcnt;
   logic [PH_W-1:0]   phase;
   logic [GAP_W-1:0]  gapcnt;
   logic [DATA_W-1:0] txsh, rxsh;
   logic [CNT_W-1:0]  cur_out, cur_dly, cur_in;
   logic              mid, eob, last_bit, out_win, in_win, first_half;

   assign cur_out = second ? out_b : out_a;
   assign cur_dly = second ? dly_b : dly_a;
   assign cur_in  = second ? in_b  : in_a;

   assign mid      = (phase == PH_W'(HALF - 1));
   assign eob      = (phase == PH_W'(TPB - 1));
   assign last_bit = (bitcnt == frame_len - CNT_W'(1));
   assign out_win  = bitcnt < cur_out;
   assign in_win   = (bitcnt >= cur_dly) &&
                     ({1'b0, bitcnt} < ({1'b0, cur_dly} + {1'b0, cur_in}));
   assign first_half = (phase < PH_W'(HALF));

   assign busy      = (state != SQ_IDLE);
   assign cs_active = (state == SQ_FRAME);
   assign finish    = cs_active && tick && eob && last_bit && (second || !two_frames);
   assign rx_word   = rxsh;
   assign mosi      = cs_active && out_win && txsh[DATA_W-1];
   assign sclk      = cs_active ? (cpol ^ (cpha ? first_half : !first_half)) : cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         second <= 1'b0;
         bitcnt <= '0;
         phase  <= '0;
         gapcnt <= '0;
         txsh   <= '0;
         rxsh   <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (start) begin
               state  <= SQ_FRAME;
               second <= 1'b0;
               bitcnt <= '0;
               phase  <= '0;
               txsh   <= tx_word;
               rxsh   <= '0;
            end
            SQ_FRAME: if (tick) begin
               phase <= eob ? '0 : phase + PH_W'(1);
               if (mid && in_win) rxsh <= {rxsh[DATA_W-2:0], miso_bit};
               if (eob) begin
                  if (out_win) txsh <= txsh << 1;
                  bitcnt <= last_bit ? '0 : bitcnt + CNT_W'(1);
                  if (last_bit) begin
                     if (!second && two_frames) begin
                        state  <= SQ_GAP;
                        gapcnt <= gap_ticks;
                     end else begin
                        state <= SQ_IDLE;
                     end
                  end
               end
            end
            SQ_GAP: if (tick) begin
               if (gapcnt == '0) begin
                  state  <= SQ_FRAME;
                  second <= 1'b1;
               end else begin
                  gapcnt <= gapcnt - GAP_W'(1);
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R2
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R7
   end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !busy);
   // R3
   tick_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> busy);
   // R4
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && $past(cs_active) && !$past(tick && eob)) |-> $stable(mosi));
endmodule

// File: rtl/serial_frame_bridge.sv
module serial_frame_bridge import sfb_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6,
   parameter int DIV_W  = 10,
   parameter int GAP_W  = 17,
   parameter int NPORT  = 3,
   parameter int TPB    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic [NPORT-1:0]  miso,
   output logic [NPORT-1:0]  cs_n
);
   logic              busy, finish, start, tick, cs_active, miso_bit;
   logic              cpol, cpha, two_frames;
   logic [DIV_W-1:0]  div;
   logic [NPORT-1:0]  port_en, miso_g;
   logic [CNT_W-1:0]  frame_len, out_a, dly_a, in_a, out_b, dly_b, in_b;
   logic [GAP_W-1:0]  gap_ticks;
   logic [DATA_W-1:0] tx_word, rx_word;

   sfb_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W),
                  .GAP_W(GAP_W), .NPORT(NPORT)) i_regs (
      .clk, .rst_n, .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
      .rd_addr(reg_raddr), .rd_data(reg_rdata), .busy, .finish, .rx_word,
      .start, .tx_word, .cpol, .cpha, .div, .two_frames, .port_en,
      .frame_len, .out_a, .dly_a, .in_a, .out_b, .dly_b, .in_b, .gap_ticks);

   sfb_tick_gen #(.DIV_W(DIV_W)) i_tick (
      .clk, .rst_n, .run(busy), .div, .tick);

   sfb_frame_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .GAP_W(GAP_W),
                   .TPB(TPB)) i_seq (
      .clk, .rst_n, .start, .tick, .two_frames, .cpol, .cpha, .miso_bit,
      .tx_word, .frame_len, .out_a, .dly_a, .in_a, .out_b, .dly_b, .in_b,
      .gap_ticks, .busy, .finish, .cs_active, .sclk, .mosi, .rx_word);

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign cs_n[p]   = ~(cs_active & port_en[p]);
      assign miso_g[p] = miso[p] & port_en[p];
   end
   assign miso_bit = |miso_g;
endmodule

// File: tb/test_serial_frame_bridge.sv
module test_serial_frame_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic        reg_wr = 0;
   logic [2:0]  reg_waddr = 0, reg_raddr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic        sclk, mosi, miso_v = 0;
   logic [2:0]  cs_n;

   serial_frame_bridge i_serial_frame_bridge (
      .clk, .rst_n, .reg_wr, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
      .sclk, .mosi, .miso({3{miso_v}}), .cs_n);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   // current transaction settings
   int size, out1, dly1, in1, out2, dly2, in2, dv, gp;
   logic cpol_s = 0, cpha_s = 0, two_s = 0;
   logic [2:0]  ports_s = 3'b001;
   logic [31:0] txd, pat;
   // slave / monitor state
   logic mon_on = 0, p_cs = 0, p_sclk = 0;
   logic mosi_seen [0:127];
   int ns, gd, runs, low_cnt, gap_cnt, viol = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic pbit(input int g);
      return pat[31 - (g % 32)];
   endfunction

   always @(negedge clk) begin
      logic cl;
      cl = ~&cs_n;
      if (mon_on) begin
         if (cl && !p_cs) begin
            runs++;
            if (!cpha_s) miso_v = pbit(gd);
         end
         if ((cl || p_cs) && sclk !== p_sclk) begin
            if ((sclk != cpol_s) == !cpha_s) begin
               if (ns < 128) mosi_seen[ns] = mosi;
               ns++;
            end else if (!cpha_s) begin
               gd++;
               miso_v = pbit(gd);
            end else begin
               miso_v = pbit(gd);
               gd++;
            end
         end
         if (cl) low_cnt++;
         else if (runs == 1) gap_cnt++;
         if (((~cs_n) & ~ports_s) != 3'b000) viol++;
      end
      p_cs = cl;
      p_sclk = sclk;
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] mode_word(input logic en);
      return (32'(ports_s) << 14) | (32'(two_s) << 13) | (32'(dv) << 3) |
             (32'(cpha_s) << 2) | (32'(cpol_s) << 1) | 32'(en);
   endfunction

   task automatic setup();
      wr(3'd0, (32'(in1) << 18) | (32'(dly1) << 12) | (32'(out1) << 6) | 32'(size));
      wr(3'd1, (32'(in2) << 12) | (32'(dly2) << 6) | 32'(out2));
      wr(3'd3, 32'(gp));
      wr(3'd2, mode_word(1'b1));
   endtask

   task automatic mon_reset();
      @(negedge clk);
      #1;
      ns = 0; gd = 0; runs = 0; low_cnt = 0; gap_cnt = 0;
      mon_on = 1;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int guard = 0;
      do begin
         @(negedge clk);
         rd(3'd5, s);
         guard++;
      end while (s[0] && guard < 20000);
   endtask

   // compares recorded mosi with the model; returns expected receive word
   task automatic model(output logic [31:0] rx_exp, output int mism);
      int g = 0, oi = 0, nf;
      logic e;
      rx_exp = 0; mism = 0;
      nf = two_s ? 2 : 1;
      for (int f = 0; f < nf; f++) begin
         for (int b = 0; b < size; b++) begin
            int oc, dl, ic;
            oc = f ? out2 : out1; dl = f ? dly2 : dly1; ic = f ? in2 : in1;
            if (b < oc) begin
               e = (oi < 32) ? txd[31 - oi] : 1'b0;
               oi++;
            end else e = 1'b0;
            if (mosi_seen[g] !== e) mism++;
            if (b >= dl && b < dl + ic) rx_exp = {rx_exp[30:0], pbit(g)};
            g++;
         end
      end
   endtask

   task automatic finish_checks(input string tag);
      logic [31:0] s, rx, rx_exp;
      int mism, nf;
      nf = two_s ? 2 : 1;
      model(rx_exp, mism);
      rd(3'd5, s);
      check({tag, " R7 busy low, done set"}, 64'(s[1:0]), 64'h2);
      rd(3'd7, rx);
      check({tag, " R6 receive word"}, 64'(rx), 64'(rx_exp));
      check({tag, " R4 mosi bit count"}, 64'(ns), 64'(nf * size));
      check({tag, " R4 mosi stream mismatches"}, 64'(mism), 64'd0);
      check({tag, " R3 chip-select low clocks"}, 64'(low_cnt), 64'(nf * size * 8 * (dv + 1)));
      check({tag, " R3 sclk idle level"}, 64'(sclk), 64'(cpol_s));
      if (two_s)
         check({tag, " R5 gap clocks"}, 64'(gap_cnt), 64'((gp + 1) * (dv + 1)));
      mon_on = 0;
   endtask

   task automatic run_txn(input string tag);
      logic [31:0] s;
      setup();
      mon_reset();
      wr(3'd6, txd);
      rd(3'd5, s);
      check({tag, " R2 busy after start"}, 64'(s[0]), 64'd1);
      wait_idle();
      finish_checks(tag);
      wr(3'd4, 32'h2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] s;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(3'd5, s); check("R1 status", 64'(s), 64'h0);
      rd(3'd7, s); check("R1 receive word", 64'(s), 64'h0);
      rd(3'd2, s); check("R1 mode word", 64'(s), 64'h4000);
      check("R1 chip selects", 64'(cs_n), 64'h7);
      check("R1 sclk", 64'(sclk), 64'h0);

      // R2 disabled bridge ignores a start
      size = 32; out1 = 32; dly1 = 0; in1 = 0; out2 = 0; dly2 = 0; in2 = 32;
      dv = 0; gp = 3; cpol_s = 0; cpha_s = 0; two_s = 1; ports_s = 3'b001;
      setup();
      wr(3'd2, mode_word(1'b0));
      mon_reset();
      wr(3'd6, 32'hFFFF_0000);
      repeat (20) @(negedge clk);
      rd(3'd5, s);
      check("R2 disabled start ignored, status", 64'(s), 64'h0);
      check("R2 disabled start, no chip select", 64'(runs), 64'd0);
      mon_on = 0;

      // directed: standard two-frame exchange (transmit then receive)
      txd = 32'hA5C3_1E96; pat = 32'h3C5A_F00F;
      run_txn("two-frame");

      // directed: single full-duplex frame, cpol1 cpha1, divider 1, ports 101 (R10)
      size = 32; out1 = 32; dly1 = 0; in1 = 32; two_s = 0;
      cpol_s = 1; cpha_s = 1; dv = 1; ports_s = 3'b101;
      txd = 32'h8000_0001; pat = 32'hDEAD_BEEF;
      run_txn("duplex");

      // directed: R8 overrun, R9 clear behaviour
      size = 16; out1 = 16; dly1 = 4; in1 = 8; two_s = 0;
      cpol_s = 0; cpha_s = 1; dv = 0; ports_s = 3'b010;
      txd = 32'h1234_5678; pat = 32'h0F0F_5A5A;
      setup();
      mon_reset();
      wr(3'd6, txd);
      repeat (10) @(negedge clk);
      wr(3'd6, 32'hFFFF_FFFF);
      wait_idle();
      finish_checks("overrun");
      rd(3'd5, s);
      check("R8 overrun sticky", 64'(s[2]), 64'd1);
      wr(3'd4, 32'h1);
      rd(3'd5, s);
      check("R9 command without clear bit keeps flags", 64'(s), 64'h6);
      wr(3'd4, 32'h2);
      rd(3'd5, s);
      check("R9 clear flags", 64'(s), 64'h0);

      // random transactions
      for (int t = 0; t < 10; t++) begin
         size = 4 + int'($urandom % 37);
         out1 = int'($urandom % (size + 1));
         dly1 = int'($urandom % (size + 1));
         in1  = int'($urandom % (size - dly1 + 1));
         out2 = int'($urandom % (size + 1));
         dly2 = int'($urandom % (size + 1));
         in2  = int'($urandom % (size - dly2 + 1));
         dv = int'($urandom % 3); gp = int'($urandom % 6);
         cpol_s = 1'($urandom); cpha_s = 1'($urandom); two_s = 1'($urandom);
         ports_s = 3'(1 + $urandom % 7);
         txd = $urandom; pat = $urandom;
         run_txn($sformatf("random%0d", t));
      end

      check("R10 chip select only on enabled ports", 64'(viol), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule